// File: doc/BRIEF.md
# CPU Architectural Register File

This block stores the programmer-visible state of an 8-bit processor that addresses a 16-bit space. That state is an accumulator, a pair of index bytes that also serve as a 16-bit pointer, a stack pointer, a program counter and an 8-bit condition code register. The datapath sequencer drives the block one cycle at a time. It sets plain enable strobes with their data, and the new register values appear on the outputs after the next rising clock edge. The sequencer and the ALU decide what to write. The block applies the per-register reset policy, resolves priority between ports, computes stack pointer arithmetic and program counter stepping, and keeps the two constant condition code bits fixed.

All ports are plain control and data pins with no handshake. Every strobe is sampled on a rising edge, and each register takes at most one update per cycle. The fixed priorities in the requirements below decide which update wins. Reset is synchronous and active low.

Top module: `cpu_regfile`

## Requirements
- R1: Reset leaves the accumulator and the low index byte unchanged. While reset is active, no write strobe changes either of them.
- R2: A clock edge with reset active makes the high index byte 0x00, the stack pointer 0x00FF, the program counter equal to `rst_vec`, and the condition code register 0x68. Reset has priority over every strobe.
- R3: `hx_q` is the high index byte above the low index byte. `h_we` and `x_we` update their own bytes independently. `hx_we` loads both bytes from `hx_wdata` and takes priority over the byte strobes.
- R4: With `sp_adj` set, the stack pointer becomes its old value plus `sp_imm` sign-extended to 16 bits, wrapping modulo 2^16.
- R5: `sp_rst_lo` sets bits 7:0 of the stack pointer to 0xFF and keeps bits 15:8. The priority order is `sp_we`, then `sp_rst_lo`, then `sp_adj`.
- R6: Bits 6 and 5 of the condition code register always read 1. Neither a full write nor a masked flag update changes them.
- R7: The condition code bits are overflow at bit 7, half-carry at bit 4, interrupt mask at bit 3, negative at bit 2, zero at bit 1 and carry at bit 0. `ccr_we` loads all writable bits from `ccr_wdata`. Otherwise each bit whose `flag_mask` bit is 1 takes the matching `flag_val` bit, and the other bits keep their value.
- R8: `pc_inc` alone advances the program counter by one, wrapping from 0xFFFF to 0x0000.
- R9: `pc_ld` loads `pc_ldata` into the program counter and takes priority over `pc_inc` in the same cycle.
- R10: `a_we` loads `a_wdata` into the accumulator on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_vec | input | 16 | Program counter value loaded at reset |
| a_we | input | 1 | Accumulator write strobe |
| a_wdata | input | 8 | Accumulator write data |
| h_we | input | 1 | High index byte write strobe |
| h_wdata | input | 8 | High index byte write data |
| x_we | input | 1 | Low index byte write strobe |
| x_wdata | input | 8 | Low index byte write data |
| hx_we | input | 1 | 16-bit index pair write strobe |
| hx_wdata | input | 16 | 16-bit index pair write data |
| sp_we | input | 1 | Stack pointer write strobe |
| sp_wdata | input | 16 | Stack pointer write data |
| sp_adj | input | 1 | Add signed immediate to stack pointer |
| sp_imm | input | 8 | Signed stack pointer adjustment |
| sp_rst_lo | input | 1 | Force stack pointer low byte to 0xFF |
| pc_inc | input | 1 | Advance program counter by one |
| pc_ld | input | 1 | Load program counter |
| pc_ldata | input | 16 | Program counter load value |
| ccr_we | input | 1 | Full condition code write strobe |
| ccr_wdata | input | 8 | Full condition code write data |
| flag_mask | input | 8 | Per-bit condition code update enables |
| flag_val | input | 8 | Per-bit condition code update values |
| a_q | output | 8 | Accumulator |
| h_q | output | 8 | High index byte |
| x_q | output | 8 | Low index byte |
| hx_q | output | 16 | Index pair as a pointer |
| sp_q | output | 16 | Stack pointer |
| pc_q | output | 16 | Program counter |
| ccr_q | output | 8 | Condition code register |

## Verification
Assertions check on every cycle the program counter stepping and load priority, the signed stack pointer adjustment, the partial reset of the stack pointer low byte, the word write of the index pair, and the forced values after a reset edge. Only the bench scenarios can show that the accumulator and the low index byte keep their contents through a reset, because before the first write those registers hold no defined value. The bench scenarios also cover the wrap cases, the strobe priority collisions, and the masked flag updates that try to touch the constant condition code bits.

// File: rtl/cpu_regs_pkg.sv
package cpu_regs_pkg;
  localparam int CCR_W = 8;
  localparam int CCR_V = 7;
  localparam int CCR_H = 4;
  localparam int CCR_I = 3;
  localparam int CCR_N = 2;
  localparam int CCR_Z = 1;
  localparam int CCR_C = 0;
  localparam logic [CCR_W-1:0] CCR_FIXED_ONES = 8'h60;
  localparam logic [CCR_W-1:0] CCR_RST_VAL    = 8'h68;
endpackage

// File: rtl/rf_index.sv
module rf_index #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_we,
  input  logic [DW-1:0]   h_wdata,
  input  logic            x_we,
  input  logic [DW-1:0]   x_wdata,
  input  logic            hx_we,
  input  logic [2*DW-1:0] hx_wdata,
  output logic [DW-1:0]   h_q,
  output logic [DW-1:0]   x_q,
  output logic [2*DW-1:0] hx_q
);
  localparam int LANES = 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          lane_we;
    logic [DW-1:0] lane_wd;
    logic [DW-1:0] lane_q;

    assign lane_we = hx_we | ((i == 1) ? h_we : x_we);
    assign lane_wd = hx_we ? hx_wdata[i*DW +: DW] : ((i == 1) ? h_wdata : x_wdata);

    if (i == 1) begin : g_forced
      always_ff @(posedge clk) begin
        if (!rst_n)       lane_q <= '0;
        else if (lane_we) lane_q <= lane_wd;
      end
    end else begin : g_kept
      always_ff @(posedge clk) begin
        if (rst_n && lane_we) lane_q <= lane_wd;
      end
    end

    assign hx_q[i*DW +: DW] = lane_q;
  end

  assign h_q = hx_q[2*DW-1:DW];
  assign x_q = hx_q[DW-1:0];

  assert_hx_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hx_we |=> hx_q == $past(hx_wdata));
endmodule

// File: rtl/rf_sp.sv
module rf_sp #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_we,
  input  logic [2*DW-1:0] sp_wdata,
  input  logic            sp_adj,
  input  logic [DW-1:0]   sp_imm,
  input  logic            sp_rst_lo,
  output logic [2*DW-1:0] sp_q
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] SP_RST = {{DW{1'b0}}, {DW{1'b1}}};

  logic [AW-1:0] imm_ext;
  logic [AW-1:0] sp_d;

  assign imm_ext = {{DW{sp_imm[DW-1]}}, sp_imm};

  always_comb begin
    sp_d = sp_q;
    if (sp_we)          sp_d = sp_wdata;
    else if (sp_rst_lo) sp_d = {sp_q[AW-1:DW], {DW{1'b1}}};
    else if (sp_adj)    sp_d = sp_q + imm_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= SP_RST;
    else        sp_q <= sp_d;
  end

  assert_sp_adj_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_adj && !sp_we && !sp_rst_lo) |=>
      sp_q == $past(sp_q) + {{DW{$past(sp_imm[DW-1])}}, $past(sp_imm)});

  assert_sp_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_rst_lo && !sp_we) |=>
      (sp_q[AW-1:DW] == $past(sp_q[AW-1:DW])) && (sp_q[DW-1:0] == {DW{1'b1}}));
endmodule

// File: rtl/rf_pc.sv
module rf_pc #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rst_vec,
  input  logic          pc_inc,
  input  logic          pc_ld,
  input  logic [AW-1:0] pc_ldata,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= rst_vec;
    else if (pc_ld)  pc_q <= pc_ldata;
    else if (pc_inc) pc_q <= pc_q + 1'b1;
  end

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_ld) |=> pc_q == $past(pc_q) + 1'b1);

  assert_pc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld |=> pc_q == $past(pc_ldata));
endmodule

// File: rtl/rf_ccr.sv
module rf_ccr
  import cpu_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ccr_we,
  input  logic [CCR_W-1:0] ccr_wdata,
  input  logic [CCR_W-1:0] flag_mask,
  input  logic [CCR_W-1:0] flag_val,
  output logic [CCR_W-1:0] ccr_q
);
  logic [CCR_W-1:0] merged;
  logic [CCR_W-1:0] ccr_d;

  always_comb begin
    if (ccr_we) merged = ccr_wdata;
    else        merged = (ccr_q & ~flag_mask) | (flag_val & flag_mask);
    ccr_d = (merged & ~CCR_FIXED_ONES) | CCR_FIXED_ONES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ccr_q <= CCR_RST_VAL;
    else        ccr_q <= ccr_d;
  end

  assert_ccr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_we |=> (ccr_q & ~CCR_FIXED_ONES) == ($past(ccr_wdata) & ~CCR_FIXED_ONES));
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_regs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*DW-1:0]   rst_vec,
  input  logic              a_we,
  input  logic [DW-1:0]     a_wdata,
  input  logic              h_we,
  input  logic [DW-1:0]     h_wdata,
  input  logic              x_we,
  input  logic [DW-1:0]     x_wdata,
  input  logic              hx_we,
  input  logic [2*DW-1:0]   hx_wdata,
  input  logic              sp_we,
  input  logic [2*DW-1:0]   sp_wdata,
  input  logic              sp_adj,
  input  logic [DW-1:0]     sp_imm,
  input  logic              sp_rst_lo,
  input  logic              pc_inc,
  input  logic              pc_ld,
  input  logic [2*DW-1:0]   pc_ldata,
  input  logic              ccr_we,
  input  logic [CCR_W-1:0]  ccr_wdata,
  input  logic [CCR_W-1:0]  flag_mask,
  input  logic [CCR_W-1:0]  flag_val,
  output logic [DW-1:0]     a_q,
  output logic [DW-1:0]     h_q,
  output logic [DW-1:0]     x_q,
  output logic [2*DW-1:0]   hx_q,
  output logic [2*DW-1:0]   sp_q,
  output logic [2*DW-1:0]   pc_q,
  output logic [CCR_W-1:0]  ccr_q
);
  localparam int AW = 2 * DW;

  always_ff @(posedge clk) begin
    if (rst_n && a_we) a_q <= a_wdata;
  end

  rf_index #(.DW(DW)) u_index (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_wdata(h_wdata),
    .x_we(x_we), .x_wdata(x_wdata),
    .hx_we(hx_we), .hx_wdata(hx_wdata),
    .h_q(h_q), .x_q(x_q), .hx_q(hx_q)
  );

  rf_sp #(.DW(DW)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .sp_we(sp_we), .sp_wdata(sp_wdata),
    .sp_adj(sp_adj), .sp_imm(sp_imm),
    .sp_rst_lo(sp_rst_lo), .sp_q(sp_q)
  );

  rf_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst_n(rst_n), .rst_vec(rst_vec),
    .pc_inc(pc_inc), .pc_ld(pc_ld), .pc_ldata(pc_ldata),
    .pc_q(pc_q)
  );

  rf_ccr u_ccr (
    .clk(clk), .rst_n(rst_n),
    .ccr_we(ccr_we), .ccr_wdata(ccr_wdata),
    .flag_mask(flag_mask), .flag_val(flag_val),
    .ccr_q(ccr_q)
  );

  assert_reset_forced_R2: assert property (@(posedge clk)
    !rst_n |=> (h_q == '0) && (sp_q == {{DW{1'b0}}, {DW{1'b1}}}) &&
               (pc_q == $past(rst_vec)) && (ccr_q == CCR_RST_VAL));

  assert_a_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> a_q == $past(a_wdata));
endmodule

// File: tb/tb_cpu_regfile.sv
module tb_cpu_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] rst_vec;
  logic        a_we, h_we, x_we, hx_we, sp_we, sp_adj, sp_rst_lo, pc_inc, pc_ld, ccr_we;
  logic [7:0]  a_wdata, h_wdata, x_wdata, sp_imm, ccr_wdata, flag_mask, flag_val;
  logic [15:0] hx_wdata, sp_wdata, pc_ldata;
  logic [7:0]  a_q, h_q, x_q, ccr_q;
  logic [15:0] hx_q, sp_q, pc_q;

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  x;
    logic [7:0]  h;
    logic [15:0] sp;
    logic [15:0] pc;
    logic [7:0]  ccr;
  } snap_t;

  snap_t m;
  snap_t exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_regfile dut (
    .clk(clk), .rst_n(rst_n), .rst_vec(rst_vec),
    .a_we(a_we), .a_wdata(a_wdata), .h_we(h_we), .h_wdata(h_wdata),
    .x_we(x_we), .x_wdata(x_wdata), .hx_we(hx_we), .hx_wdata(hx_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_adj(sp_adj), .sp_imm(sp_imm),
    .sp_rst_lo(sp_rst_lo), .pc_inc(pc_inc), .pc_ld(pc_ld), .pc_ldata(pc_ldata),
    .ccr_we(ccr_we), .ccr_wdata(ccr_wdata), .flag_mask(flag_mask), .flag_val(flag_val),
    .a_q(a_q), .h_q(h_q), .x_q(x_q), .hx_q(hx_q), .sp_q(sp_q), .pc_q(pc_q), .ccr_q(ccr_q)
  );

  task automatic idle();
    rst_n = 1'b1;
    {a_we, h_we, x_we, hx_we, sp_we, sp_adj, sp_rst_lo, pc_inc, pc_ld, ccr_we} = '0;
    {a_wdata, h_wdata, x_wdata, sp_imm, ccr_wdata, flag_mask, flag_val} = '0;
    {hx_wdata, sp_wdata, pc_ldata} = '0;
  endtask

  // Reference model from the requirements, then push the expectation.
  task automatic step(input string tag, input bit push);
    logic [7:0] mg;
    if (!rst_n) begin
      m.h = 8'h00; m.sp = 16'h00FF; m.pc = rst_vec; m.ccr = 8'h68;
    end else begin
      if (a_we) m.a = a_wdata;
      if (hx_we) begin m.h = hx_wdata[15:8]; m.x = hx_wdata[7:0]; end
      else begin
        if (h_we) m.h = h_wdata;
        if (x_we) m.x = x_wdata;
      end
      if (sp_we)          m.sp = sp_wdata;
      else if (sp_rst_lo) m.sp = {m.sp[15:8], 8'hFF};
      else if (sp_adj)    m.sp = m.sp + {{8{sp_imm[7]}}, sp_imm};
      if (pc_ld)          m.pc = pc_ldata;
      else if (pc_inc)    m.pc = m.pc + 16'd1;
      mg = ccr_we ? ccr_wdata : ((m.ccr & ~flag_mask) | (flag_val & flag_mask));
      m.ccr = mg | 8'h60;
    end
    if (push) begin exp_q.push_back(m); tag_q.push_back(tag); end
    @(negedge clk);
    idle();
  endtask

  // Monitor: compare one result per cycle after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      snap_t e, act;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = '{a: a_q, x: x_q, h: h_q, sp: sp_q, pc: pc_q, ccr: ccr_q};
      checks++;
      if (act !== e || hx_q !== {e.h, e.x}) begin
        fails++;
        $display("FAIL %s: actual a=%h x=%h h=%h hx=%h sp=%h pc=%h ccr=%h expected a=%h x=%h h=%h hx=%h sp=%h pc=%h ccr=%h",
                 t, a_q, x_q, h_q, hx_q, sp_q, pc_q, ccr_q,
                 e.a, e.x, e.h, {e.h, e.x}, e.sp, e.pc, e.ccr);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_vec = 16'hC000;
    m = '0;
    @(negedge clk);
    rst_n = 1'b0; step("init", 0);
    rst_n = 1'b0; step("init", 0);
    // R10 R3: independent writes
    a_we = 1; a_wdata = 8'h3C; x_we = 1; x_wdata = 8'h5A; h_we = 1; h_wdata = 8'h12;
    step("R10 R3 byte writes", 1);
    hx_we = 1; hx_wdata = 16'hBEEF; h_we = 1; h_wdata = 8'h11; x_we = 1; x_wdata = 8'h22;
    step("R3 word write wins", 1);
    x_we = 1; x_wdata = 8'h77;
    step("R3 low byte only", 1);
    sp_we = 1; sp_wdata = 16'h2000; pc_ld = 1; pc_ldata = 16'h4000; ccr_we = 1; ccr_wdata = 8'h01;
    step("setup pre-reset", 1);
    // R1 R2: reset with strobes active
    rst_n = 0; a_we = 1; a_wdata = 8'h99; x_we = 1; x_wdata = 8'h99; h_we = 1; h_wdata = 8'h99;
    pc_ld = 1; pc_ldata = 16'h1111;
    step("R1 R2 reset keeps A X forces rest", 1);
    pc_inc = 1; step("R8 pc increment", 1);
    pc_inc = 1; step("R8 pc increment again", 1);
    pc_ld = 1; pc_ldata = 16'hFFFF; pc_inc = 1; step("R9 load beats increment", 1);
    pc_inc = 1; step("R8 pc wrap", 1);
    sp_we = 1; sp_wdata = 16'h0140; step("sp write", 1);
    sp_adj = 1; sp_imm = 8'hF0; step("R4 negative adjust", 1);
    sp_adj = 1; sp_imm = 8'h7F; step("R4 positive adjust", 1);
    sp_we = 1; sp_wdata = 16'h0010; step("sp write low", 1);
    sp_adj = 1; sp_imm = 8'h80; step("R4 wrap below zero", 1);
    sp_rst_lo = 1; sp_adj = 1; sp_imm = 8'h05; step("R5 low byte reset beats adjust", 1);
    sp_we = 1; sp_wdata = 16'h1234; step("sp write", 1);
    sp_rst_lo = 1; step("R5 keeps high byte", 1);
    sp_we = 1; sp_wdata = 16'h0A0B; sp_rst_lo = 1; step("R5 write beats low byte reset", 1);
    ccr_we = 1; ccr_wdata = 8'h00; step("R6 full write of zeros", 1);
    ccr_we = 1; ccr_wdata = 8'hFF; step("R6 R7 full write of ones", 1);
    flag_mask = 8'h63; flag_val = 8'h01; step("R6 R7 masked flags", 1);
    flag_mask = 8'h08; flag_val = 8'h00; step("R7 clear interrupt mask", 1);
    ccr_we = 1; ccr_wdata = 8'h82; flag_mask = 8'hFF; flag_val = 8'h00;
    step("R7 full write beats mask", 1);
    a_we = 1; a_wdata = 8'hA5; step("R10 accumulator write", 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule